// File: doc/BRIEF.md
# Receive Descriptor Poll Controller

This block is the control state machine of a receive DMA engine that walks a list of descriptors kept in host memory. Software sets the list's base address while the engine is stopped and then issues a start command. The engine keeps a current-descriptor pointer and reads one descriptor at a time over a single-beat read port. For each descriptor it checks only the ownership bit. A descriptor owned by the DMA keeps the engine running. A descriptor still owned by the host makes the engine suspend and raises a buffer-unavailable flag.

A suspended engine wakes up only through the poll-demand register. Writing that register with any data makes the engine read the descriptor under the current pointer again. Once the current buffer has been used, the data path pulses `buf_done`, and the engine moves the pointer on by one descriptor stride and fetches the next descriptor. Frame data, buffer pointers and bus arbitration are handled outside this block.

Top module: `rxdesc_poll_ctrl`

## Requirements
- R1: A start command in the stopped state loads the pointer from the base register and issues a descriptor read at that address on the next cycle. `state` then reads 1 (running). State codes: 0 stopped, 1 running, 2 suspended.
- R2: A read that returns `rd_own`=1 leaves the engine running with no request pending. A `buf_done` pulse in that condition advances the pointer by `DESC_BYTES` and issues a new read.
- R3: A read that returns `rd_own`=0 while running moves the engine to suspended and sets `buf_unavail`. This is the only way into the suspended state.
- R4: While suspended and idle, a register write with `reg_sel`=1 and any data reads the descriptor at the unchanged pointer again. If that descriptor is still host-owned, the engine stays suspended and `buf_unavail` is not set again.
- R5: If the descriptor read after a poll demand is DMA-owned, the engine returns to running.
- R6: A write with `reg_sel`=0 stores the base with its low log2(`BUS_W`/8) bits forced to zero. With the default `BUS_W`=64 these are bits [2:0]. `base_addr` reads back those bits as zero.
- R7: A base write while running or suspended leaves `base_addr` unchanged and sets the sticky `wr_err` flag.
- R8: `rd_req` and `rd_addr` hold until `rd_ack`. A stop command returns the engine to stopped once any read in flight completes. A read that completes under a pending stop neither suspends the engine nor sets `buf_unavail`.
- R9: A register write with `reg_sel`=2 clears `buf_unavail` if bit 0 of the data is 1, and clears `wr_err` if bit 1 of the data is 1.
- R10: After reset the base, pointer and both flags are 0, `state` is 0 and `rd_req` is low.
- R11: A poll demand while running or stopped issues no read. A start command while running or suspended leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 base, 1 poll demand, 2 status clear |
| reg_wdata | input | AW | Write data |
| cmd_start | input | 1 | Start command |
| cmd_stop | input | 1 | Stop command |
| buf_done | input | 1 | Current DMA-owned buffer consumed |
| rd_req | output | 1 | Descriptor read request, held until ack |
| rd_addr | output | AW | Descriptor read address |
| rd_ack | input | 1 | Read response valid |
| rd_own | input | 1 | Ownership bit of response, 1 = DMA |
| base_addr | output | AW | Aligned list base |
| cur_ptr | output | AW | Current-descriptor pointer |
| state | output | 2 | 0 stopped, 1 running, 2 suspended |
| buf_unavail | output | 1 | Sticky buffer-unavailable flag |
| wr_err | output | 1 | Sticky illegal base write flag |

## Verification
The assertions check properties that must hold on every cycle. Suspension only ever follows a host-owned response seen while running. The base register stays aligned and does not move under a locked write. A pending request holds its address until acknowledged. A stopped engine never requests a read. Only the directed scenarios can show the ordering effects: the pointer stride, the refetch after a poll at the same address, the flag that is not raised again after a failed poll, a stop waiting for its read, and the commands that are ignored in the wrong state.

// File: rtl/rxdesc_poll_ctrl.sv
module rxdesc_poll_ctrl #(
  parameter int AW = 32,
  parameter int BUS_W = 64,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          buf_done,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic          rd_own,
  output logic [AW-1:0] base_addr,
  output logic [AW-1:0] cur_ptr,
  output logic [1:0]    state,
  output logic          buf_unavail,
  output logic          wr_err
);
  localparam int LOW = $clog2(BUS_W / 8);
  localparam logic [AW-1:0] LOW_MASK = (AW'(1) << LOW) - AW'(1);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);
  localparam logic [1:0] ST_STOP = 2'd0, ST_RUN = 2'd1, ST_SUSP = 2'd2;

  logic [1:0]    st;
  logic          pend, stopping, unav_q, werr_q;
  logic [AW-1:0] base_q, ptr_q;

  wire wr_base  = reg_wr && reg_sel == 2'd0;
  wire wr_poll  = reg_wr && reg_sel == 2'd1;
  wire wr_stat  = reg_wr && reg_sel == 2'd2;
  wire fin      = pend && rd_ack;
  wire stop_now = cmd_stop || stopping;
  wire set_unav = fin && !rd_own && st == ST_RUN && !stop_now;

  assign rd_req      = pend;
  assign rd_addr     = ptr_q;
  assign cur_ptr     = ptr_q;
  assign base_addr   = base_q;
  assign state       = st;
  assign buf_unavail = unav_q;
  assign wr_err      = werr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_STOP;
      pend     <= 1'b0;
      stopping <= 1'b0;
      unav_q   <= 1'b0;
      werr_q   <= 1'b0;
      base_q   <= '0;
      ptr_q    <= '0;
    end else begin
      if (wr_base && st == ST_STOP) base_q <= reg_wdata & ~LOW_MASK;

      if (wr_base && st != ST_STOP) werr_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) werr_q <= 1'b0;

      if (set_unav) unav_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) unav_q <= 1'b0;

      if (st == ST_STOP) begin
        stopping <= 1'b0;
        if (cmd_start) begin
          ptr_q <= base_q;
          pend  <= 1'b1;
          st    <= ST_RUN;
        end
      end else begin
        if (cmd_stop && pend && !fin) stopping <= 1'b1;
        if (fin) begin
          pend <= 1'b0;
          if (stop_now) begin
            st       <= ST_STOP;
            stopping <= 1'b0;
          end else if (rd_own) st <= ST_RUN;
          else if (st == ST_RUN) st <= ST_SUSP;
        end else if (!pend && stop_now) begin
          st       <= ST_STOP;
          stopping <= 1'b0;
        end else if (!pend) begin
          if (st == ST_RUN && buf_done) begin
            ptr_q <= ptr_q + STRIDE;
            pend  <= 1'b1;
          end
          if (st == ST_SUSP && wr_poll) pend <= 1'b1;
        end
      end
    end
  end
endmodule

module rxdesc_poll_chk #(
  parameter int AW = 32,
  parameter int BUS_W = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          rd_own,
  input logic [AW-1:0] base_addr,
  input logic [1:0]    state,
  input logic          buf_unavail
);
  localparam int LOW = $clog2(BUS_W / 8);

  a_r3_suspend_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && $past(state) == 2'd1) |-> $past(rd_req && rd_ack && !rd_own));

  a_r3_unavail_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_unavail) |-> ($past(state) == 2'd1 && $past(rd_ack && !rd_own)));

  a_r6_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    base_addr[LOW-1:0] == '0);

  a_r7_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && state != 2'd0) |=> $stable(base_addr));

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  a_r8_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> !rd_req);
endmodule

bind rxdesc_poll_ctrl rxdesc_poll_chk #(.AW(AW), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_own(rd_own),
  .base_addr(base_addr), .state(state), .buf_unavail(buf_unavail)
);

// File: tb/sim_rxdesc_poll_ctrl.sv
module sim_rxdesc_poll_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, cmd_start = 0, cmd_stop = 0, buf_done = 0, rd_ack = 0, rd_own = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic rd_req, buf_unavail, wr_err;
  logic [31:0] rd_addr, base_addr, cur_ptr;
  logic [1:0] state;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  rxdesc_poll_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pulse_start(); cmd_start = 1; @(negedge clk); cmd_start = 0; endtask
  task automatic pulse_stop();  cmd_stop = 1;  @(negedge clk); cmd_stop = 0;  endtask
  task automatic pulse_done();  buf_done = 1;  @(negedge clk); buf_done = 0;  endtask

  task automatic respond(logic own);
    rd_ack = 1; rd_own = own;
    @(negedge clk);
    rd_ack = 0;
  endtask

  task automatic t_reset();
    chk("R10 state", 32'(state), 0);
    chk("R10 base", base_addr, 0);
    chk("R10 ptr", cur_ptr, 0);
    chk("R10 flags", {30'd0, buf_unavail, wr_err}, 0);
    chk("R10 req", 32'(rd_req), 0);
  endtask

  task automatic t_align();
    wr(2'd0, 32'h1000_0007);
    chk("R6 base low bits", base_addr, 32'h1000_0000);
    chk("R7 no err when stopped", 32'(wr_err), 0);
  endtask

  task automatic t_run_path();
    pulse_start();
    chk("R1 req", 32'(rd_req), 1);
    chk("R1 addr", rd_addr, 32'h1000_0000);
    chk("R1 state", 32'(state), 1);
    @(negedge clk);
    chk("R8 req held", 32'(rd_req), 1);
    respond(1);
    chk("R2 running", 32'(state), 1);
    chk("R2 idle", 32'(rd_req), 0);
    chk("R2 no unavail", 32'(buf_unavail), 0);
    pulse_done();
    chk("R2 next addr", rd_addr, 32'h1000_0010);
    chk("R2 req", 32'(rd_req), 1);
    respond(0);
    chk("R3 suspended", 32'(state), 2);
    chk("R3 unavail", 32'(buf_unavail), 1);
  endtask

  task automatic t_locked_base();
    wr(2'd0, 32'h2222_0000);
    chk("R7 base kept", base_addr, 32'h1000_0000);
    chk("R7 err set", 32'(wr_err), 1);
    wr(2'd2, 32'h1);
    chk("R9 unavail cleared", 32'(buf_unavail), 0);
    chk("R9 err kept", 32'(wr_err), 1);
    wr(2'd2, 32'h2);
    chk("R9 err cleared", 32'(wr_err), 0);
  endtask

  task automatic t_poll();
    wr(2'd1, 32'h0);
    chk("R4 refetch req", 32'(rd_req), 1);
    chk("R4 same addr", rd_addr, 32'h1000_0010);
    respond(0);
    chk("R4 stays suspended", 32'(state), 2);
    chk("R4 unavail not reset", 32'(buf_unavail), 0);
    wr(2'd1, 32'hDEAD_BEEF);
    chk("R4 second poll req", 32'(rd_req), 1);
    respond(1);
    chk("R5 running", 32'(state), 1);
  endtask

  task automatic t_ignored();
    wr(2'd1, 32'h5);
    chk("R11 poll while running", 32'(rd_req), 0);
    pulse_start();
    chk("R11 start while running", cur_ptr, 32'h1000_0010);
    chk("R11 no req", 32'(rd_req), 0);
  endtask

  task automatic t_stop();
    pulse_done();
    chk("R2 third addr", rd_addr, 32'h1000_0020);
    pulse_stop();
    chk("R8 waits for read", 32'(state), 1);
    chk("R8 req still", 32'(rd_req), 1);
    respond(0);
    chk("R8 stopped", 32'(state), 0);
    chk("R8 no unavail on stop", 32'(buf_unavail), 0);
    wr(2'd1, 32'h1);
    chk("R11 poll while stopped", 32'(rd_req), 0);
    wr(2'd0, 32'h0000_2000);
    chk("R6 new base", base_addr, 32'h0000_2000);
    pulse_start();
    chk("R1 restart addr", rd_addr, 32'h0000_2000);
    respond(1);
    pulse_stop();
    chk("R8 idle stop", 32'(state), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_align();
        t_run_path();
        t_locked_base();
        t_poll();
        t_ignored();
        t_stop();
      end
      begin
        repeat (5000) @(negedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule